// File: doc/BRIEF.md
# Wide-Register Abstract Access Unit

This block lets a debug module read and write the general registers of one halted hart whose registers are one bit wider than XLEN. The debugger puts a value in a staging word, issues a register-access command (register number, size code, direction, transfer flag), waits while `busy` is high, and reads the staging word back. Failures are reported through a sticky three-bit error code.

The standard integer register window covers only the low XLEN bits. The extra bit of each register has its own window at `EXT_BASE + N` (0xC000 by default, inside the nonstandard range). To save a register in full, the debugger reads the normal number, then the window number, and joins the two results. The window is present only when `extEnable` is high. When it is low, an access to the window is refused. Ordinary accesses work the same way in both cases. A write through the normal path clears the extra bit. This stops a debugger that does not know about the window from leaving a stale extra bit behind.

Top module: `wide_reg_cmd_unit`

## Requirements
- R1: After reset, `busy` is 0, `cmdErr` is 0, `dataOut` is 0, and every register reads 0 in both windows.
- R2: A command with transfer=1 and size code 2 (32 bits) on number 0x1000+N behaves by direction. A write (write=1) copies the staging word into xN. A read copies xN into the staging word.
- R3: With `extEnable`=1, a read of 0xC000+N returns the extra bit of xN in bit 0 and zeros in bits above it. A write there sets only that bit, from staging bit 0, and the low XLEN bits of xN stay as they were.
- R4: A write through the normal number 0x1000+N clears the extra bit of xN to 0.
- R5: x0 reads 0 in both windows, and writes to x0 in either window have no effect.
- R6: With `extEnable`=0, an access to 0xC000..0xC01F sets `cmdErr` to 2 (not supported). `busy` stays low, and the staging word and all registers are left unchanged.
- R7: The following accesses set `cmdErr` to 2 without raising `busy`: a size code other than 2..4; a size larger than XLEN (codes 3 = 64 bits and 4 = 128 bits when XLEN is 32); any register number outside the two implemented windows, which includes CSRs 0x0000..0x0FFF and floating-point registers 0x1020..0x103F.
- R8: A command with transfer=0 touches no register and no staging data, and it ends with `cmdErr` still 0, whatever its number or size.
- R9: An accepted command holds `busy` high for exactly CMD_LAT cycles (3 by default). The result is in `dataOut` by the time `busy` falls.
- R10: Issuing a command while `busy` is high sets `cmdErr` to 1 (busy). The new command is dropped, and the command already running completes normally.
- R11: A nonzero `cmdErr` stays until it is cleared. While it is nonzero, new commands are ignored. Pulsing `errClr` clears the bits of `cmdErr` that are set in `errClrBits`.
- R12: Staging writes (`dataWe`) are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command issue strobe |
| cmdRegNo | input | 16 | Register number |
| cmdSize | input | 3 | Access size code (2 = 32, 3 = 64, 4 = 128 bits) |
| cmdWrite | input | 1 | 1 = write register from staging, 0 = read into staging |
| cmdTransfer | input | 1 | 1 = perform the register access |
| dataWe | input | 1 | Load staging word from `dataIn` |
| dataIn | input | XLEN | New staging value |
| errClr | input | 1 | Apply write-ones-to-clear to the error code |
| errClrBits | input | 3 | Bits of the error code to clear |
| extEnable | input | 1 | Hart implements the extra-bit window |
| busy | output | 1 | Command in progress |
| cmdErr | output | 3 | Command error code (0 none, 1 busy, 2 not supported) |
| dataOut | output | XLEN | Staging word |

## Verification
The checker asserts the following on every cycle:
- the busy window has exactly CMD_LAT cycles;
- the error code is sticky, and it blocks new commands;
- the busy error is raised on overlap;
- an unsupported size or a disabled window is refused at once;
- the staging word stays stable while a command is in flight.

Only the bench scenarios can show the register contents. These are the two-step save of a full register, the clearing of the extra bit by a normal write, the x0 behaviour, and the fact that a refused window access left the register untouched. The bench checks them by reading the registers back through the command path and comparing with its reference model.

// File: rtl/wide_reg_cmd_pkg.sv
package wide_reg_cmd_pkg;

  localparam int GPR_COUNT = 32;
  localparam int IDX_W = $clog2(GPR_COUNT);
  localparam logic [15:0] GPR_BASE = 16'h1000;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_BUSY       = 3'd1,
    ERR_NOTSUP     = 3'd2,
    ERR_EXCEPTION  = 3'd3,
    ERR_HALTRESUME = 3'd4,
    ERR_BUS        = 3'd5,
    ERR_OTHER      = 3'd7
  } cmd_err_e;

  // Strobes from control to datapath, valid for a single cycle.
  typedef struct packed {
    logic             doRead;
    logic             doWrite;
    logic             extWin;
    logic [IDX_W-1:0] idx;
    logic [2:0]       sizeEnc;
  } dp_strobe_t;

  function automatic int accessBits(input logic [2:0] enc);
    case (enc)
      3'd2:    return 32;
      3'd3:    return 64;
      3'd4:    return 128;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wide_reg_cmd_ctrl.sv
module wide_reg_cmd_ctrl
  import wide_reg_cmd_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CMD_LAT  = 3,
  parameter logic [15:0] EXT_BASE = 16'hC000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdRegNo,
  input  logic [2:0]  cmdSize,
  input  logic        cmdWrite,
  input  logic        cmdTransfer,
  input  logic        errClr,
  input  logic [2:0]  errClrBits,
  input  logic        extEnable,
  output logic        busy,
  output logic [2:0]  cmdErr,
  output dp_strobe_t  strobe
);

  localparam int CNT_W = $clog2(CMD_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [2:0]       errQ;
  logic             opXfer;
  logic             opWrite;
  logic             opExt;
  logic [IDX_W-1:0] opIdx;
  logic [2:0]       opSize;

  logic isGprNo, isExtNo, sizeOk, targetOk, refuse, lastCycle;
  logic [2:0] errAfterClr;
  int   reqBits;

  always_comb begin
    isGprNo  = (cmdRegNo[15:IDX_W] == GPR_BASE[15:IDX_W]);
    isExtNo  = (cmdRegNo[15:IDX_W] == EXT_BASE[15:IDX_W]);
    reqBits  = accessBits(cmdSize);
    sizeOk   = (reqBits != 0) && (reqBits <= XLEN);
    targetOk = isGprNo || (isExtNo && extEnable);
    refuse   = cmdTransfer && !(sizeOk && targetOk);
    errAfterClr = errQ & ~(errClr ? errClrBits : 3'b000);
  end

  assign busy      = (cnt != '0);
  assign lastCycle = (cnt == CNT_W'(1));
  assign cmdErr    = errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      errQ    <= ERR_NONE;
      opXfer  <= 1'b0;
      opWrite <= 1'b0;
      opExt   <= 1'b0;
      opIdx   <= '0;
      opSize  <= '0;
    end else begin
      errQ <= errAfterClr;
      if (busy) cnt <= cnt - CNT_W'(1);
      if (cmdValid) begin
        if (busy) begin
          if (errQ == ERR_NONE) errQ <= ERR_BUSY;
        end else if (errQ == ERR_NONE) begin
          if (refuse) begin
            errQ <= ERR_NOTSUP;
          end else begin
            cnt     <= CNT_W'(CMD_LAT);
            opXfer  <= cmdTransfer;
            opWrite <= cmdWrite;
            opExt   <= isExtNo;
            opIdx   <= cmdRegNo[IDX_W-1:0];
            opSize  <= cmdSize;
          end
        end
      end
    end
  end

  always_comb begin
    strobe.doRead  = lastCycle && opXfer && !opWrite;
    strobe.doWrite = lastCycle && opXfer && opWrite;
    strobe.extWin  = opExt;
    strobe.idx     = opIdx;
    strobe.sizeEnc = opSize;
  end

endmodule

// File: rtl/wide_reg_cmd_dp.sv
module wide_reg_cmd_dp
  import wide_reg_cmd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busy,
  input  logic            dataWe,
  input  logic [XLEN-1:0] dataIn,
  input  dp_strobe_t      strobe,
  output logic [XLEN-1:0] dataOut
);

  logic [XLEN-1:0] gprRow [GPR_COUNT];
  logic [GPR_COUNT-1:0] extRow;
  logic [XLEN-1:0] stage;
  logic [XLEN-1:0] sizeMask;
  logic [XLEN-1:0] rdVal;
  int              nBits;

  always_comb begin
    nBits = accessBits(strobe.sizeEnc);
    if (nBits >= XLEN) sizeMask = '1;
    else               sizeMask = (XLEN'(1) << nBits) - XLEN'(1);
  end

  // Row 0 is hard-wired to zero; rows 1.. are written by strobe.
  assign gprRow[0] = '0;
  assign extRow[0] = 1'b0;

  for (genvar g = 1; g < GPR_COUNT; g++) begin : g_row
    logic [XLEN-1:0] rowQ;
    logic            extQ;
    logic            hit;
    assign hit = strobe.doWrite && (strobe.idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rowQ <= '0;
        extQ <= 1'b0;
      end else if (hit) begin
        if (strobe.extWin) begin
          extQ <= stage[0];
        end else begin
          rowQ <= stage & sizeMask;
          extQ <= 1'b0;
        end
      end
    end
    assign gprRow[g] = rowQ;
    assign extRow[g] = extQ;
  end

  always_comb begin
    if (strobe.extWin) rdVal = {{(XLEN-1){1'b0}}, extRow[strobe.idx]};
    else               rdVal = gprRow[strobe.idx] & sizeMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                stage <= '0;
    else if (strobe.doRead)   stage <= rdVal;
    else if (dataWe && !busy) stage <= dataIn;
  end

  assign dataOut = stage;

endmodule

// File: rtl/wide_reg_cmd_unit.sv
module wide_reg_cmd_unit
  import wide_reg_cmd_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CMD_LAT  = 3,
  parameter logic [15:0] EXT_BASE = 16'hC000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [15:0]     cmdRegNo,
  input  logic [2:0]      cmdSize,
  input  logic            cmdWrite,
  input  logic            cmdTransfer,
  input  logic            dataWe,
  input  logic [XLEN-1:0] dataIn,
  input  logic            errClr,
  input  logic [2:0]      errClrBits,
  input  logic            extEnable,
  output logic            busy,
  output logic [2:0]      cmdErr,
  output logic [XLEN-1:0] dataOut
);

  dp_strobe_t strobe;

  wide_reg_cmd_ctrl #(.XLEN(XLEN), .CMD_LAT(CMD_LAT), .EXT_BASE(EXT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRegNo(cmdRegNo),
    .cmdSize(cmdSize), .cmdWrite(cmdWrite), .cmdTransfer(cmdTransfer),
    .errClr(errClr), .errClrBits(errClrBits), .extEnable(extEnable),
    .busy(busy), .cmdErr(cmdErr), .strobe(strobe)
  );

  wide_reg_cmd_dp #(.XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .dataWe(dataWe), .dataIn(dataIn),
    .strobe(strobe), .dataOut(dataOut)
  );

endmodule

// File: rtl/wide_reg_cmd_unit_chk.sv
module wide_reg_cmd_unit_chk #(
  parameter int          XLEN     = 32,
  parameter int          CMD_LAT  = 3,
  parameter logic [15:0] EXT_BASE = 16'hC000
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [15:0]     cmdRegNo,
  input logic [2:0]      cmdSize,
  input logic            cmdTransfer,
  input logic            errClr,
  input logic            extEnable,
  input logic            busy,
  input logic [2:0]      cmdErr,
  input logic [XLEN-1:0] dataOut
);

  int busyRun;
  logic extNo;
  assign extNo = (cmdRegNo >= EXT_BASE) && (cmdRegNo < EXT_BASE + 16'd32);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == CMD_LAT); // R9

  AST_WIN_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdErr == 3'd0 && cmdTransfer && extNo && !extEnable)
      |=> (cmdErr == 3'd2 && !busy && $stable(dataOut))); // R6

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdErr == 3'd0 && cmdTransfer && (cmdSize < 3'd2 || cmdSize > 3'd4))
      |=> (cmdErr == 3'd2 && !busy)); // R7

  AST_OVERLAP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid && cmdErr == 3'd0) |=> cmdErr == 3'd1); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr != 3'd0 && !errClr) |=> $stable(cmdErr)); // R11

  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr != 3'd0 && !busy) |=> !busy); // R11

  AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(dataOut)); // R12

endmodule

bind wide_reg_cmd_unit wide_reg_cmd_unit_chk #(.XLEN(XLEN), .CMD_LAT(CMD_LAT), .EXT_BASE(EXT_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRegNo(cmdRegNo), .cmdSize(cmdSize),
  .cmdTransfer(cmdTransfer), .errClr(errClr), .extEnable(extEnable),
  .busy(busy), .cmdErr(cmdErr), .dataOut(dataOut)
);

// File: tb/wide_reg_cmd_unit_tb.sv
module wide_reg_cmd_unit_tb;

  localparam int XLEN = 32;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdWrite = 0, cmdTransfer = 0, dataWe = 0, errClr = 0, extEnable = 0;
  logic [15:0] cmdRegNo = 0;
  logic [2:0]  cmdSize = 0, errClrBits = 0;
  logic [XLEN-1:0] dataIn = 0;
  logic busy;
  logic [2:0] cmdErr;
  logic [XLEN-1:0] dataOut;

  always #4 clk = ~clk;

  wide_reg_cmd_unit #(.XLEN(XLEN), .CMD_LAT(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRegNo(cmdRegNo), .cmdSize(cmdSize),
    .cmdWrite(cmdWrite), .cmdTransfer(cmdTransfer), .dataWe(dataWe), .dataIn(dataIn),
    .errClr(errClr), .errClrBits(errClrBits), .extEnable(extEnable),
    .busy(busy), .cmdErr(cmdErr), .dataOut(dataOut)
  );

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // Behavioural reference model
  int unsigned gprM [32];
  bit          extM [32];
  int unsigned dataM;
  int          errM, cntM;
  bit          pXfer, pWrite, pExt;
  int          pIdx;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (gprM[i]) begin gprM[i] = 0; extM[i] = 0; end
      dataM = 0; errM = 0; cntM = 0;
    end else begin
      bit wasBusy;
      int e, bits;
      bit isG, isE, ok;
      wasBusy = (cntM != 0);
      if (cntM == 1 && pXfer) begin
        if (pWrite) begin
          if (pIdx != 0) begin
            if (pExt) extM[pIdx] = dataM[0];
            else begin gprM[pIdx] = dataM; extM[pIdx] = 0; end
          end
        end else begin
          if (pIdx == 0) dataM = 0;
          else if (pExt) dataM = extM[pIdx];
          else dataM = gprM[pIdx];
        end
      end
      if (cntM > 0) cntM--;
      if (dataWe && !wasBusy) dataM = dataIn;
      e = errClr ? (errM & ~int'(errClrBits)) : errM;
      if (cmdValid) begin
        if (wasBusy) begin
          if (errM == 0) e = 1;
        end else if (errM == 0) begin
          bits = (cmdSize == 2) ? 32 : (cmdSize == 3) ? 64 : (cmdSize == 4) ? 128 : 0;
          isG = (cmdRegNo >= 16'h1000 && cmdRegNo < 16'h1020);
          isE = (cmdRegNo >= 16'hC000 && cmdRegNo < 16'hC020);
          ok = (bits != 0) && (bits <= XLEN) && (isG || (isE && extEnable));
          if (cmdTransfer && !ok) e = 2;
          else begin
            cntM = LAT; pXfer = cmdTransfer; pWrite = cmdWrite; pExt = isE;
            pIdx = cmdRegNo[4:0];
          end
        end
      end
      errM = e;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      compared++;
      if (busy !== (cntM != 0) || cmdErr !== 3'(errM) || dataOut !== dataM) begin
        mismatched++;
        $display("FAIL %s model: busy=%0b err=%0d data=%h expected busy=%0b err=%0d data=%h",
                 curReq, busy, cmdErr, dataOut, (cntM != 0), errM, dataM);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] no, input logic [2:0] sz, input logic wr, input logic xf);
    cmdValid = 1; cmdRegNo = no; cmdSize = sz; cmdWrite = wr; cmdTransfer = xf;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic setData(input logic [31:0] v);
    dataWe = 1; dataIn = v;
    @(negedge clk);
    dataWe = 0;
  endtask

  task automatic clearErr(input logic [2:0] b);
    errClr = 1; errClrBits = b;
    @(negedge clk);
    errClr = 0;
  endtask

  task automatic rd(input logic [15:0] no, output logic [31:0] v);
    issue(no, 3'd2, 1'b0, 1'b1); waitIdle(); v = dataOut;
  endtask

  task automatic wrReg(input logic [15:0] no, input logic [31:0] v);
    setData(v); issue(no, 3'd2, 1'b1, 1'b1); waitIdle();
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curReq = "R1";
    chk("R1 busy", 32'(busy), 0); chk("R1 err", 32'(cmdErr), 0); chk("R1 data", dataOut, 0);
    rd(16'h1005, v); chk("R1 x5", v, 0);

    curReq = "R2";
    wrReg(16'h1005, 32'hA5A5_0001); setData(0);
    rd(16'h1005, v); chk("R2 x5 readback", v, 32'hA5A5_0001);
    wrReg(16'h101F, 32'h1234_5678); rd(16'h101F, v); chk("R2 x31", v, 32'h1234_5678);

    curReq = "R3"; extEnable = 1;
    wrReg(16'hC005, 32'h0000_0001);
    rd(16'h1005, v); chk("R3 low part kept", v, 32'hA5A5_0001);
    rd(16'hC005, v); chk("R3 ext bit", v, 1);
    wrReg(16'hC007, 32'hFFFF_FFFF); rd(16'hC007, v); chk("R3 upper zero", v, 1);
    rd(16'h1007, v); chk("R3 x7 low", v, 0);

    curReq = "R4";
    wrReg(16'h1005, 32'h0000_0123); rd(16'hC005, v); chk("R4 ext cleared", v, 0);

    curReq = "R5";
    wrReg(16'h1000, 32'hDEAD_BEEF); rd(16'h1000, v); chk("R5 x0", v, 0);
    wrReg(16'hC000, 32'h1); rd(16'hC000, v); chk("R5 x0 ext", v, 0);

    curReq = "R6"; extEnable = 0;
    wrReg(16'hC031 - 16'h30, 32'h0); // 0xC001 write of 0 while disabled
    chk("R6 err", 32'(cmdErr), 2); chk("R6 busy", 32'(busy), 0);
    clearErr(3'b111);
    setData(32'h1); issue(16'hC007, 3'd2, 1'b1, 1'b1); waitIdle();
    chk("R6 err2", 32'(cmdErr), 2); chk("R6 stage kept", dataOut, 1);
    clearErr(3'b111); extEnable = 1;
    rd(16'hC007, v); chk("R6 reg unchanged", v, 1);

    curReq = "R7";
    issue(16'h1005, 3'd3, 1'b0, 1'b1); waitIdle(); chk("R7 size64", 32'(cmdErr), 2); clearErr(3'b111);
    issue(16'h1005, 3'd4, 1'b0, 1'b1); waitIdle(); chk("R7 size128", 32'(cmdErr), 2); clearErr(3'b111);
    issue(16'h1005, 3'd0, 1'b0, 1'b1); waitIdle(); chk("R7 size0", 32'(cmdErr), 2); clearErr(3'b111);
    issue(16'h0300, 3'd2, 1'b0, 1'b1); waitIdle(); chk("R7 csr", 32'(cmdErr), 2); clearErr(3'b111);
    issue(16'h1020, 3'd2, 1'b0, 1'b1); waitIdle(); chk("R7 fpr", 32'(cmdErr), 2); clearErr(3'b111);

    curReq = "R8";
    setData(32'h5555_AAAA);
    issue(16'h2000, 3'd7, 1'b0, 1'b0); chk("R8 busy", 32'(busy), 1); waitIdle();
    chk("R8 err", 32'(cmdErr), 0); chk("R8 stage", dataOut, 32'h5555_AAAA);

    curReq = "R9";
    issue(16'h101F, 3'd2, 1'b0, 1'b1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 busy cycles", n, LAT); chk("R9 result", dataOut, 32'h1234_5678);

    curReq = "R10";
    setData(32'h0BAD_0BAD);
    issue(16'h1005, 3'd2, 1'b0, 1'b1);
    issue(16'h1009, 3'd2, 1'b1, 1'b1);
    waitIdle();
    chk("R10 err", 32'(cmdErr), 1); chk("R10 first done", dataOut, 32'h123);

    curReq = "R11";
    issue(16'h1009, 3'd2, 1'b1, 1'b1); chk("R11 blocked", 32'(busy), 0);
    clearErr(3'b100); chk("R11 partial clear", 32'(cmdErr), 1);
    clearErr(3'b001); chk("R11 cleared", 32'(cmdErr), 0);
    rd(16'h1009, v); chk("R10 dropped write", v, 0);

    curReq = "R12";
    issue(16'h101F, 3'd2, 1'b0, 1'b1);
    setData(32'hCAFE_F00D);
    waitIdle(); chk("R12 stage", dataOut, 32'h1234_5678);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule